// File: doc/BRIEF.md
# Packed Single-to-Double Float Widener

This block takes two IEEE-754 single-precision numbers packed in a 64-bit operand and widens each one to an IEEE-754 double. The two doubles are packed into a 128-bit result. Each lane's conversion is exact. Normal numbers are rebiased. Denormal inputs are normalized into normal doubles. Signaling NaNs are quieted and keep their payload. Zeros, infinities and quiet NaNs keep their value. Each operation reports an Invalid flag and a Denormal flag, and the flags also collect into a sticky status.

The operand port is 128 bits wide, so a full register can be presented directly. Only the low 64 bits are used. The block also chooses the fault for each operation from three inputs: a task-switched control bit, an OS exception-support control bit, and per-flag mask bits. A device-unavailable fault suppresses the operation entirely. When an unmasked flag is raised, the destination write is withheld. That case becomes a floating-point fault only when OS support is enabled. All outputs are registered and appear one cycle after the request.

Top module: `pk_widen_sd`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous clock edge. All outputs are zero after reset.
- R2: Source bits [31:0] convert into `result_o[63:0]`, and source bits [63:32] convert into `result_o[127:64]`.
- R3: Bits [127:64] of `src_i` have no effect on any output.
- R4: A normal single keeps its sign. Its exponent is increased by 896. Its 23-bit fraction becomes the top of the 52-bit fraction, followed by 29 zero bits.
- R5: A zero or an infinity keeps its sign and maps to the double zero or the double infinity. It raises no flag.
- R6: A NaN with fraction bit 22 clear is a signaling NaN. It sets Invalid (`flags_o[0]`) and produces a double NaN with fraction bit 51 set and source fraction bits [21:0] placed in bits [50:29]. A NaN with fraction bit 22 set is a quiet NaN. It is carried over the same way and raises no flag.
- R7: A nonzero single with a zero exponent sets Denormal (`flags_o[1]`). It is converted to the exactly equal normal double: exponent 896 minus the leading-zero count of the fraction, and the fraction shifted left past its leading one.
- R8: When `ts_i` is 1 on a valid request, the block raises `fault_nm_o` with `we_o`, `fault_xm_o` and `flags_o` all at 0. `result_o` and `sticky_o` keep their previous values.
- R9: With `ts_i` at 0, an exception is unmasked when a raised flag has its `mask_i` bit (same position) at 0. In that case `we_o` is 0, and `fault_xm_o` is 1 only if `os_xe_i` is 1. Otherwise `we_o` is 1 and `result_o` takes the new result.
- R10: `sticky_o` is the OR of the flags of every operation since reset that was not device-unavailable. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| src_i | input | 128 | Source operand; only bits [63:0] are used |
| ts_i | input | 1 | Task-switched control bit |
| os_xe_i | input | 1 | OS support for floating-point exception faults |
| mask_i | input | 2 | Exception masks: [0] Invalid, [1] Denormal |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 128 | Two packed doubles |
| we_o | output | 1 | Destination write enable |
| flags_o | output | 2 | Flags of this operation: [0] Invalid, [1] Denormal |
| sticky_o | output | 2 | Accumulated flags |
| fault_nm_o | output | 1 | Device-unavailable fault |
| fault_xm_o | output | 1 | Floating-point exception fault |

## Verification
The datapath has no state except its output registers, so a conversion fault shows up as a wrong result one cycle after the request. The bench therefore sweeps every leading-zero count of a denormal fraction, both NaN kinds, and each lane separately. The real state is the sticky register and the held result. A wrong update of either can stay hidden until a later operation. For that reason they are compared on every clock, including idle cycles and cycles with a device-unavailable fault.

// File: rtl/pk_widen_pkg.sv
package pk_widen_pkg;
  localparam int SP_W     = 32;
  localparam int SP_EXP_W = 8;
  localparam int SP_FRC_W = 23;
  localparam int SP_BIAS  = 127;
  localparam int DP_W     = 64;
  localparam int DP_EXP_W = 11;
  localparam int DP_FRC_W = 52;
  localparam int DP_BIAS  = 1023;
  localparam int LANES    = 2;
  localparam int BIAS_ADJ = DP_BIAS - SP_BIAS;
  localparam int PAD_W    = DP_FRC_W - SP_FRC_W;

  // bit 0 invalid, bit 1 denormal
  typedef struct packed {
    logic den;
    logic inv;
  } fp_flags_t;
endpackage

// File: rtl/pk_lzc.sv
module pk_lzc #(
  parameter int W  = 23,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o
);
  logic found;
  always_comb begin
    cnt_o = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (d_i[i]) found = 1'b1;
        else        cnt_o = CW'(cnt_o + 1'b1);
      end
    end
  end
endmodule

// File: rtl/pk_lane_cvt.sv
module pk_lane_cvt
  import pk_widen_pkg::*;
(
  input  logic [SP_W-1:0] sp_i,
  output logic [DP_W-1:0] dp_o,
  output fp_flags_t       flags_o
);
  localparam int LZ_W = $clog2(SP_FRC_W + 1);

  logic                sgn;
  logic [SP_EXP_W-1:0] exp_s;
  logic [SP_FRC_W-1:0] frc_s;
  logic [LZ_W-1:0]     lz;
  logic [SP_FRC_W-1:0] frc_sh;
  logic [SP_FRC_W-1:0] frc_norm;
  logic [DP_EXP_W-1:0] exp_norm;
  logic [DP_EXP_W-1:0] exp_den;

  assign sgn   = sp_i[SP_W-1];
  assign exp_s = sp_i[SP_W-2 -: SP_EXP_W];
  assign frc_s = sp_i[SP_FRC_W-1:0];

  pk_lzc #(.W(SP_FRC_W), .CW(LZ_W)) u_lzc (
    .d_i  (frc_s),
    .cnt_o(lz)
  );

  // drop the leading one after normalizing
  assign frc_sh   = frc_s << lz;
  assign frc_norm = {frc_sh[SP_FRC_W-2:0], 1'b0};
  assign exp_norm = DP_EXP_W'(exp_s) + DP_EXP_W'(BIAS_ADJ);
  assign exp_den  = DP_EXP_W'(BIAS_ADJ) - DP_EXP_W'(lz);

  always_comb begin
    flags_o = '0;
    if (exp_s == '1) begin
      if (frc_s == '0) begin
        dp_o = {sgn, {DP_EXP_W{1'b1}}, {DP_FRC_W{1'b0}}};
      end else begin
        dp_o        = {sgn, {DP_EXP_W{1'b1}}, 1'b1, frc_s[SP_FRC_W-2:0], {PAD_W{1'b0}}};
        flags_o.inv = ~frc_s[SP_FRC_W-1];
      end
    end else if (exp_s == '0) begin
      if (frc_s == '0) begin
        dp_o = {sgn, {(DP_W-1){1'b0}}};
      end else begin
        dp_o        = {sgn, exp_den, frc_norm, {PAD_W{1'b0}}};
        flags_o.den = 1'b1;
      end
    end else begin
      dp_o = {sgn, exp_norm, frc_s, {PAD_W{1'b0}}};
    end
  end
endmodule

// File: rtl/pk_fault_sel.sv
module pk_fault_sel
  import pk_widen_pkg::*;
(
  input  fp_flags_t  flags_i,
  input  logic [1:0] mask_i,
  input  logic       ts_i,
  input  logic       os_xe_i,
  output logic       we_o,
  output logic       nm_o,
  output logic       xm_o,
  output fp_flags_t  flags_o
);
  logic unmasked;

  assign unmasked = |(flags_i & ~mask_i);
  assign nm_o     = ts_i;
  assign we_o     = ~ts_i & ~unmasked;
  assign xm_o     = ~ts_i & unmasked & os_xe_i;
  assign flags_o  = ts_i ? '0 : flags_i;
endmodule

// File: rtl/pk_widen_sd.sv
module pk_widen_sd
  import pk_widen_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [2*DP_W-1:0]     src_i,
  input  logic                  ts_i,
  input  logic                  os_xe_i,
  input  logic [1:0]            mask_i,
  output logic                  valid_o,
  output logic [LANES*DP_W-1:0] result_o,
  output logic                  we_o,
  output logic [1:0]            flags_o,
  output logic [1:0]            sticky_o,
  output logic                  fault_nm_o,
  output logic                  fault_xm_o
);
  localparam int RES_W = LANES * DP_W;

  logic [RES_W-1:0] res_c;
  fp_flags_t        lane_fl [LANES];
  fp_flags_t        fl_or;
  fp_flags_t        fl_eff;
  logic             we_c, nm_c, xm_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pk_lane_cvt u_cvt (
      .sp_i   (src_i[g*SP_W +: SP_W]),
      .dp_o   (res_c[g*DP_W +: DP_W]),
      .flags_o(lane_fl[g])
    );
  end

  always_comb begin
    fl_or = '0;
    for (int i = 0; i < LANES; i++) fl_or = fl_or | lane_fl[i];
  end

  pk_fault_sel u_fsel (
    .flags_i(fl_or),
    .mask_i (mask_i),
    .ts_i   (ts_i),
    .os_xe_i(os_xe_i),
    .we_o   (we_c),
    .nm_o   (nm_c),
    .xm_o   (xm_c),
    .flags_o(fl_eff)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      we_o       <= 1'b0;
      flags_o    <= '0;
      sticky_o   <= '0;
      fault_nm_o <= 1'b0;
      fault_xm_o <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      we_o       <= valid_i & we_c;
      fault_nm_o <= valid_i & nm_c;
      fault_xm_o <= valid_i & xm_c;
      flags_o    <= valid_i ? fl_eff : '0;
      if (valid_i) sticky_o <= sticky_o | fl_eff;
      if (valid_i && !ts_i) result_o <= res_c;
    end
  end
endmodule

// File: rtl/pk_widen_chk.sv
module pk_widen_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         ts_i,
  input logic         os_xe_i,
  input logic         valid_o,
  input logic [127:0] result_o,
  input logic         we_o,
  input logic [1:0]   flags_o,
  input logic [1:0]   sticky_o,
  input logic         fault_nm_o,
  input logic         fault_xm_o
);
  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!we_o && !fault_nm_o && !fault_xm_o && flags_o == 2'b00));
  a_r8_nm_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_nm_o |-> (!we_o && !fault_xm_o && flags_o == 2'b00));
  a_r8_nm_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ts_i) |=> ($stable(result_o) && $stable(sticky_o)));
  a_r9_xm_needs_os: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !os_xe_i) |=> !fault_xm_o);
  a_r9_we_xm_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_o, fault_xm_o, fault_nm_o}));
  a_r10_sticky_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));
endmodule

bind pk_widen_sd pk_widen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .ts_i      (ts_i),
  .os_xe_i   (os_xe_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .we_o      (we_o),
  .flags_o   (flags_o),
  .sticky_o  (sticky_o),
  .fault_nm_o(fault_nm_o),
  .fault_xm_o(fault_xm_o)
);

// File: tb/sim_pk_widen_sd.sv
`timescale 1ns/1ps
module sim_pk_widen_sd;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_i = 1'b0;
  logic [127:0] src_i = '0;
  logic         ts_i = 1'b0, os_xe_i = 1'b0;
  logic [1:0]   mask_i = 2'b11;
  logic         valid_o, we_o, fault_nm_o, fault_xm_o;
  logic [127:0] result_o;
  logic [1:0]   flags_o, sticky_o;

  always #2.5 clk = ~clk;

  pk_widen_sd u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_i(src_i),
    .ts_i(ts_i), .os_xe_i(os_xe_i), .mask_i(mask_i),
    .valid_o(valid_o), .result_o(result_o), .we_o(we_o), .flags_o(flags_o),
    .sticky_o(sticky_o), .fault_nm_o(fault_nm_o), .fault_xm_o(fault_xm_o)
  );

  typedef struct {
    bit           v;
    logic [127:0] res;
    logic [1:0]   fl;
    logic [1:0]   st;
    bit           we, nm, xm;
    string        tag;
  } exp_t;

  exp_t         q[$];
  logic [127:0] held_res = '0;
  logic [1:0]   st_model = '0;
  int           checks = 0, errors = 0;

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // exact widening by repeated normalization
  task automatic ref_cvt(input logic [31:0] x, output logic [63:0] d,
                         output logic inv, output logic den);
    int         e, ee;
    logic [23:0] m;
    e = int'(x[30:23]);
    m = {1'b0, x[22:0]};
    inv = 1'b0; den = 1'b0;
    if (e == 255) begin
      if (m == 0) d = {x[31], 11'h7ff, 52'd0};
      else begin
        inv = ~x[22];
        d = {x[31], 11'h7ff, 1'b1, x[21:0], 29'd0};
      end
    end else if (e == 0) begin
      if (m == 0) d = {x[31], 63'd0};
      else begin
        den = 1'b1;
        ee = -126;
        while (!m[23]) begin m = m << 1; ee--; end
        d = {x[31], 11'(ee + 1023), m[22:0], 29'd0};
      end
    end else begin
      d = {x[31], 11'(e - 127 + 1023), x[22:0], 29'd0};
    end
  endtask

  task automatic cmp_outputs();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(e.tag, "valid_o", 128'(valid_o), 128'(e.v));
    chk(e.tag, "result_o", result_o, e.res);
    chk(e.tag, "flags_o", 128'(flags_o), 128'(e.fl));
    chk(e.tag, "we_o", 128'(we_o), 128'(e.we));
    chk(e.tag, "fault_nm_o", 128'(fault_nm_o), 128'(e.nm));
    chk(e.tag, "fault_xm_o", 128'(fault_xm_o), 128'(e.xm));
    chk({e.tag, " R10"}, "sticky_o", 128'(sticky_o), 128'(e.st));
  endtask

  task automatic op(string tag, bit v, logic [127:0] src, bit ts, bit os, logic [1:0] mask);
    exp_t        e;
    logic [63:0] d0, d1;
    logic        i0, i1, n0, n1, unm;
    logic [1:0]  fl;
    @(negedge clk);
    cmp_outputs();
    valid_i = v; src_i = src; ts_i = ts; os_xe_i = os; mask_i = mask;
    ref_cvt(src[31:0], d0, i0, n0);
    ref_cvt(src[63:32], d1, i1, n1);
    fl  = {n0 | n1, i0 | i1};
    unm = |(fl & ~mask);
    e.tag = tag; e.v = v; e.we = 0; e.nm = 0; e.xm = 0; e.fl = 2'b00;
    if (v && ts) e.nm = 1;
    else if (v) begin
      held_res = {d1, d0};
      e.fl = fl;
      e.we = !unm;
      e.xm = unm && os;
      st_model = st_model | fl;
    end
    e.res = held_res;
    e.st  = st_model;
    q.push_back(e);
  endtask

  task automatic cvt(string tag, logic [31:0] lo, logic [31:0] hi);
    op(tag, 1, {64'h0, hi, lo}, 0, 0, 2'b11);
  endtask

  function automatic logic [31:0] rnd_sp(int kind);
    logic [31:0] r;
    r = $urandom;
    case (kind)
      0: begin r[30:23] = 8'($urandom_range(1, 254)); end
      1: r[30:0] = '0;
      2: begin r[30:23] = 8'hff; r[22:0] = '0; end
      3: begin r[30:23] = 8'hff; r[22] = 1'b1; end
      4: begin r[30:23] = 8'hff; r[22] = 1'b0; r[0] = 1'b1; end
      default: begin r[30:23] = 8'h00; r[0] = r[0] | (r[22:1] == 0); end
    endcase
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", "valid_o", 128'(valid_o), 128'(0));
    chk("R1 reset", "result_o", result_o, 128'(0));
    chk("R10 reset", "sticky_o", 128'(sticky_o), 128'(0));
    chk("R8 reset", "faults", 128'({fault_nm_o, fault_xm_o, we_o}), 128'(0));
    rst_n = 1'b1;

    op("R1 idle", 0, '0, 0, 0, 2'b11);
    cvt("R4 one/two", 32'h3f80_0000, 32'h4000_0000);
    cvt("R2 lanes distinct", 32'hc2f6_e979, 32'h3eaa_aaab);
    cvt("R4 extremes", 32'h0080_0000, 32'h7f7f_ffff);
    cvt("R5 zeros", 32'h0000_0000, 32'h8000_0000);
    cvt("R5 infinities", 32'h7f80_0000, 32'hff80_0000);
    cvt("R6 quiet nan", 32'h7fc1_2345, 32'hffff_ffff);
    op("R3 upper ignored a", 1, {64'hdead_beef_0123_4567, 32'h4049_0fdb, 32'hbf00_0000}, 0, 0, 2'b11);
    op("R3 upper ignored b", 1, {64'hffff_ffff_ffff_ffff, 32'h4049_0fdb, 32'hbf00_0000}, 0, 0, 2'b11);
    op("R3 upper nan ignored", 1, {64'h7f80_0001_ff80_0001, 32'h3f80_0000, 32'h3f80_0000}, 0, 0, 2'b00);
    cvt("R6 signaling nan lo", 32'h7f80_0001, 32'h3f80_0000);
    cvt("R6 signaling nan hi", 32'h3f80_0000, 32'hffa5_5555);
    for (int lz = 0; lz < 23; lz++) begin
      logic [31:0] f;
      f = 32'(1) << (22 - lz);
      f = f | (32'($urandom) & (f - 1));
      cvt($sformatf("R7 denorm lz=%0d", lz), {1'b0, 8'h00, f[22:0]}, {1'b1, 8'h00, f[22:0]});
    end
    cvt("R7 denorm min", 32'h0000_0001, 32'h807f_ffff);

    op("R8 ts fault", 1, {64'h0, 32'h7f80_0001, 32'h0000_0001}, 1, 1, 2'b00);
    op("R8 ts fault normal", 1, {64'h0, 32'h3f80_0000, 32'h4000_0000}, 1, 0, 2'b11);
    op("R9 inv unmasked os", 1, {64'h0, 32'h3f80_0000, 32'h7f80_0002}, 0, 1, 2'b10);
    op("R9 inv unmasked no os", 1, {64'h0, 32'h3f80_0000, 32'h7f80_0002}, 0, 0, 2'b10);
    op("R9 den unmasked os", 1, {64'h0, 32'h0000_0010, 32'h3f80_0000}, 0, 1, 2'b01);
    op("R9 den masked inv unmasked", 1, {64'h0, 32'h0000_0010, 32'h3f80_0000}, 0, 1, 2'b10);
    op("R9 clean unmasked", 1, {64'h0, 32'h4000_0000, 32'h3f80_0000}, 0, 1, 2'b00);
    op("R1 idle after", 0, '0, 0, 0, 2'b00);

    for (int n = 0; n < 600; n++) begin
      logic [127:0] s;
      s = {$urandom, $urandom, rnd_sp($urandom_range(0, 5)), rnd_sp($urandom_range(0, 5))};
      op("R2 random", $urandom_range(0, 3) != 0, s, $urandom_range(0, 7) == 0,
         1'($urandom), 2'($urandom));
    end

    op("R1 drain", 0, '0, 0, 0, 2'b11);
    op("R1 drain", 0, '0, 0, 0, 2'b11);
    @(negedge clk);
    cmp_outputs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule